// File: doc/BRIEF.md
# Four-Operation Mode-Select ALU

This block is a small combinational arithmetic/logic unit for 4-bit operands. It is built from two halves. An arithmetic half holds one ripple-carry adder with a conditioning multiplexer in front of it. A logic half computes bitwise functions. An output multiplexer, steered by a mode bit, chooses which half drives the result. A function bit then picks one of the two operations within the chosen half, so the unit offers four operations in all.

Subtraction uses the same adder as addition. The second operand is inverted and the adder's carry input is raised, so the adder forms X + ~Y + 1. The unit holds no state: the result follows the operands and select bits with no clock involved. It suits a datapath that registers the result itself.

Top module: `alu4_mode`

## Requirements
- R1: With mode_i = 0 and func_i = 0, g_o equals (x_i + y_i) mod 16 and carry_o equals bit 4 of the 5-bit sum.
- R2: With mode_i = 0 and func_i = 1, g_o equals (x_i - y_i) mod 16, and carry_o is 1 exactly when x_i >= y_i as unsigned values (carry set means no borrow).
- R3: With mode_i = 1 and func_i = 0, g_o equals the bitwise AND of x_i and y_i.
- R4: With mode_i = 1 and func_i = 1, g_o equals the bitwise XOR of x_i and y_i.
- R5: With mode_i = 1, carry_o is 0 for every operand value.
- R6: The block holds no state: g_o and carry_o settle to the values above after an input change, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4 | First operand |
| y_i | input | 4 | Second operand |
| mode_i | input | 1 | 0 selects the arithmetic half, 1 selects the logic half |
| func_i | input | 1 | Operation within the half: add/AND when 0, subtract/XOR when 1 |
| g_o | output | 4 | Result |
| carry_o | output | 1 | Adder carry-out in arithmetic mode, 0 in logic mode |

## Verification
The assertions are immediate checks evaluated whenever the ports change. They assume every input is a known 0/1 value, because an X on a select bit would make them meaningless. The stimulus drives only fully defined values. It covers all 1024 input combinations once and then adds seeded random vectors. Inputs change half a cycle away from the sampling point, so each check reads settled outputs.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu4_arith.sv
module alu4_arith #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_cond;
  logic [W:0]   c;

  // operand conditioning: invert b for subtract
  always_comb b_cond = sub_i ? ~b_i : b_i;
  assign c[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_cond[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_cond[i]) | (c[i] & (a_i[i] ^ b_cond[i]));
  end

  assign cout_o = c[W];
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] res_o
);
  always_comb res_o = sel_i ? (a_i ^ b_i) : (a_i & b_i);
endmodule

// File: rtl/alu4_mode_mux.sv
module alu4_mode_mux #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] arith_i,
  input  logic         arith_c_i,
  input  logic [W-1:0] logic_i,
  input  logic         mode_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = mode_i ? logic_i : arith_i;
    c_o   = mode_i ? 1'b0 : arith_c_i;
  end
endmodule

// File: rtl/alu4_mode.sv
module alu4_mode #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         mode_i,
  input  logic         func_i,
  output logic [W-1:0] g_o,
  output logic         carry_o
);
  import alu4_pkg::*;

  alu_op_e      op;
  logic [W-1:0] arith_res, logic_res;
  logic         arith_c;

  assign op = alu_op_e'({mode_i, func_i});

  alu4_arith #(.W(W)) u_arith (
    .a_i   (x_i),
    .b_i   (y_i),
    .sub_i (op == OP_SUB),
    .sum_o (arith_res),
    .cout_o(arith_c)
  );

  alu4_logic #(.W(W)) u_logic (
    .a_i  (x_i),
    .b_i  (y_i),
    .sel_i(op == OP_XOR),
    .res_o(logic_res)
  );

  alu4_mode_mux #(.W(W)) u_mux (
    .arith_i  (arith_res),
    .arith_c_i(arith_c),
    .logic_i  (logic_res),
    .mode_i   (mode_i),
    .res_o    (g_o),
    .c_o      (carry_o)
  );
endmodule

// File: rtl/alu4_mode_chk.sv
module alu4_mode_chk #(
  parameter int unsigned W = 4
) (
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic         mode_i,
  input logic         func_i,
  input logic [W-1:0] g_o,
  input logic         carry_o
);
  always_comb begin
    if (!mode_i && !func_i) begin
      // R1
      add_inverse_chk: assert ((({carry_o, g_o}) - {1'b0, y_i}) == {1'b0, x_i});
    end
    if (!mode_i && func_i) begin
      // R2
      sub_inverse_chk: assert (W'(g_o + y_i) == x_i);
      // R2
      sub_borrow_chk: assert (carry_o == (x_i >= y_i));
    end
    if (mode_i && !func_i) begin
      // R3
      and_subset_chk: assert (((g_o & ~x_i) | (g_o & ~y_i)) == '0);
    end
    if (mode_i && func_i) begin
      // R4
      xor_inverse_chk: assert ((g_o ^ y_i) == x_i);
    end
    if (mode_i) begin
      // R5
      logic_no_carry_chk: assert (!carry_o);
    end
  end
endmodule

bind alu4_mode alu4_mode_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu4_mode.sv
module sim_alu4_mode;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] x, y, g;
  logic       mode, func, carry;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  alu4_mode u0 (.x_i(x), .y_i(y), .mode_i(mode), .func_i(func), .g_o(g), .carry_o(carry));

  function automatic logic [4:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic m, input logic f);
    case ({m, f})
      2'b00:   return {1'b0, a} + {1'b0, b};
      2'b01:   return {(a >= b), 4'(a - b)};
      2'b10:   return {1'b0, a & b};
      default: return {1'b0, a ^ b};
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s x=%h y=%h m=%b f=%b actual=%h expected=%h", req, x, y, mode, func, act, exp);
    end
  endtask

  function automatic string tag(input logic m, input logic f);
    case ({m, f})
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3 R5";
      default: return "R4 R5";
    endcase
  endfunction

  task automatic run(input logic [3:0] a, input logic [3:0] b, input logic m, input logic f);
    @(negedge clk);
    x = a; y = b; mode = m; func = f;
    @(posedge clk);
    #1;
    check(tag(m, f), {carry, g}, model(a, b, m, f));
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    x = '0; y = '0; mode = 1'b0; func = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", {carry, g}, 5'h00);
    rst_ni = 1'b1;
    // directed corners
    run(4'hF, 4'h1, 1'b0, 1'b0);  // R1 wrap, carry 1
    run(4'h4, 4'h3, 1'b0, 1'b0);  // R1
    run(4'h3, 4'h4, 1'b0, 1'b1);  // R2 borrow
    run(4'h7, 4'h7, 1'b0, 1'b1);  // R2 equal, carry 1
    run(4'h0, 4'hF, 1'b0, 1'b1);  // R2
    run(4'hF, 4'hF, 1'b1, 1'b0);  // R3, R5 carry stays 0
    run(4'hA, 4'h5, 1'b1, 1'b1);  // R4
    // R6: change inputs with no clock edge, output follows
    @(negedge clk);
    x = 4'h9; y = 4'h8; mode = 1'b0; func = 1'b0;
    #2;
    check("R6 no-clock add", {carry, g}, 5'h11);
    func = 1'b1;
    #2;
    check("R6 no-clock sub", {carry, g}, 5'h11);
    mode = 1'b1;
    #2;
    check("R6 no-clock xor", {carry, g}, 5'h01);
    // exhaustive sweep
    for (int i = 0; i < 1024; i++)
      run(i[3:0], i[7:4], i[8], i[9]);
    // seeded random
    for (int i = 0; i < 300; i++)
      run(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule